// File: doc/BRIEF.md
# Short Frame Padder and FCS Appender

This block sits in the transmit path of an Ethernet MAC, between the byte stream that carries frame payloads and the line-side logic. Both sides use a valid/ready byte stream with first-byte and last-byte markers. Each frame carries two per-frame control flags, one that suppresses padding and one that suppresses the frame check sequence. Both flags are read only together with the first byte of the frame.

Payload bytes pass straight through in the cycle they arrive. When the last payload byte has been accepted, the block may take over the output. If the frame is shorter than the minimum and padding is allowed, it emits zero bytes until the payload reaches the minimum frame length less four. Then, if an FCS is due, it emits the four CRC-32 bytes. A padded frame always gets its FCS, whatever the CRC-suppress flag says. The upstream side is held off (`in_ready` low) while inserted bytes are going out.

Top module: `frame_pad_fcs`

## Requirements
- R1: In the payload phase, `out_valid`, `out_data` and `out_first` follow `in_valid`, `in_data` and `in_first` in the same cycle, and `in_ready` follows `out_ready`. Payload bytes leave unchanged and in order.
- R2: A frame is short when its payload has fewer than MIN_FRAME-4 bytes (60 by default). If the no-pad flag is 0 at the first byte, a short frame is followed by 0x00 bytes until the payload plus pad is exactly 60 bytes. A frame of 60 or more bytes receives no pad.
- R3: The FCS is four bytes of CRC-32, taken over the payload and pad bytes. It uses the reflected polynomial 0xEDB88320, starts from 0xFFFFFFFF and is inverted at the end. Its least significant byte is sent first. It is appended when the no-CRC flag is 0 at the first byte.
- R4: A frame that received pad bytes always gets the FCS, even when its no-CRC flag is 1. The output frame is then exactly MIN_FRAME (64) bytes.
- R5: A frame with no-CRC set and no padding gets no FCS. Its output `out_last` is on its final payload byte.
- R6: With no-pad set, a short frame leaves unpadded. It gets an FCS only if no-CRC is 0.
- R7: `in_nopad` and `in_nocrc` are sampled only on the handshake of a byte with `in_first`=1. Their values on later bytes of the frame have no effect.
- R8: `out_last` is 1 only on the final byte of each output frame: the last FCS byte, or the last payload byte when no FCS is sent. The next byte handshaked is the first byte of the next frame.
- R9: `in_ready` is 0 in every cycle in which a pad or FCS byte is offered.
- R10: When `out_ready` is low, the block stalls. An offered byte stays stable until it is taken, and no byte is lost or repeated.
- R11: After reset, the block is in the payload phase with nothing pending, so `out_valid` is 0 while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input payload byte |
| in_first | input | 1 | First byte of a frame |
| in_last | input | 1 | Last payload byte of a frame |
| in_nopad | input | 1 | Suppress padding (read with the first byte) |
| in_nocrc | input | 1 | Suppress FCS (read with the first byte) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Line side accepts a byte |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of an output frame |
| out_last | output | 1 | Last byte of an output frame |

## Verification
Payload bytes appear on the output in the same cycle they are offered, with no register in between. Each pad or FCS byte appears in the cycle after the previous output handshake, the first one right after the handshake of the last payload byte. The bench drives each stimulus just after the falling edge and waits 1 ns for the combinational path to settle. It then reads both handshakes before the next rising edge, so every output is judged in the cycle it is due. Under backpressure the bench also compares a stalled byte with the byte offered in the following cycle.

// File: rtl/fpf_pkg.sv
package fpf_pkg;

   localparam logic [31:0] FCS_POLY = 32'hEDB88320;

   typedef enum logic [1:0] {
      PH_DATA = 2'd0,
      PH_PAD  = 2'd1,
      PH_FCS  = 2'd2
   } phase_t;

   // one byte through the reflected CRC-32, one bit at a time
   function automatic logic [31:0] crc_step_bits(input logic [31:0] c_in,
                                                 input logic [7:0]  d);
      logic [31:0] c;
      c = c_in ^ {24'd0, d};
      for (int k = 0; k < 8; k++) begin
         c = c[0] ? ((c >> 1) ^ FCS_POLY) : (c >> 1);
      end
      return c;
   endfunction

   // remainder of a 4-bit value shifted four times through the polynomial
   function automatic logic [31:0] crc_nib_entry(input logic [3:0] n);
      logic [31:0] c;
      c = {28'd0, n};
      for (int k = 0; k < 4; k++) begin
         c = c[0] ? ((c >> 1) ^ FCS_POLY) : (c >> 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/fpf_crc32.sv
module fpf_crc32 #(
   parameter int DATA_W    = 8,
   parameter bit NIB_TABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              en,
   input  logic [DATA_W-1:0] din,
   output logic [31:0]       crc_q
);
   import fpf_pkg::*;

   logic [31:0] crc_nxt;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("fpf_crc32: DATA_W must be 8");
      end
      if (NIB_TABLE) begin : g_nibble
         logic [31:0] half;
         always_comb begin
            half    = (crc_q >> 4) ^ crc_nib_entry(crc_q[3:0] ^ din[3:0]);
            crc_nxt = (half >> 4) ^ crc_nib_entry(half[3:0] ^ din[7:4]);
         end
      end else begin : g_bitwise
         always_comb crc_nxt = crc_step_bits(crc_q, din);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= '1;
      else if (clr)    crc_q <= '1;
      else if (en)     crc_q <= crc_nxt;
   end

endmodule

// File: rtl/fpf_len_cnt.sv
module fpf_len_cnt #(
   parameter int LIMIT = 60,
   parameter int CW    = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("fpf_len_cnt: LIMIT must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (clr)                  cnt <= '0;
      else if (inc && cnt != LIM_V)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/frame_pad_fcs.sv
module frame_pad_fcs #(
   parameter int DATA_W    = 8,
   parameter int MIN_FRAME = 64,
   parameter bit NIB_TABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_first,
   input  logic              in_last,
   input  logic              in_nopad,
   input  logic              in_nocrc,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_first,
   output logic              out_last
);
   import fpf_pkg::*;

   localparam int FCS_BYTES = 4;
   localparam int PAY_MIN   = MIN_FRAME - FCS_BYTES;
   localparam int CW        = $clog2(PAY_MIN + 1);
   localparam logic [CW:0] PAY_MIN_V = (CW + 1)'(PAY_MIN);

   generate
      if (MIN_FRAME <= FCS_BYTES) begin : g_bad_min
         $error("frame_pad_fcs: MIN_FRAME must exceed the FCS length");
      end
      if (DATA_W != 8) begin : g_bad_dw
         $error("frame_pad_fcs: byte stream only");
      end
   endgenerate

   phase_t         ph;
   logic           nopad_q, nocrc_q;
   logic [1:0]     fidx;
   logic [CW-1:0]  cnt;
   logic [CW:0]    cnt_plus;
   logic [31:0]    crc_q;
   logic [31:0]    fcs_word;
   logic           nopad_eff, nocrc_eff;
   logic           short_after, need_pad, need_fcs;
   logic           hs, frame_end, feed;
   logic           ins_busy, pad_on;

   // per-frame flags: live on the first byte, held afterwards
   assign nopad_eff   = in_first ? in_nopad : nopad_q;
   assign nocrc_eff   = in_first ? in_nocrc : nocrc_q;
   assign cnt_plus    = {1'b0, cnt} + 1'b1;
   assign short_after = (cnt_plus < PAY_MIN_V);
   assign need_pad    = short_after && !nopad_eff;
   assign need_fcs    = need_pad || !nocrc_eff;
   assign fcs_word    = ~crc_q;

   always_comb begin
      in_ready  = 1'b0;
      out_valid = 1'b0;
      out_data  = '0;
      out_first = 1'b0;
      out_last  = 1'b0;
      unique case (ph)
         PH_DATA: begin
            out_valid = in_valid;
            out_data  = in_data;
            out_first = in_first;
            out_last  = in_last && !need_fcs;
            in_ready  = out_ready;
         end
         PH_PAD: begin
            out_valid = 1'b1;
         end
         PH_FCS: begin
            out_valid = 1'b1;
            out_data  = fcs_word[{fidx, 3'b000} +: 8];
            out_last  = (fidx == 2'd3);
         end
         default: begin
            out_valid = 1'b0;
         end
      endcase
   end

   assign hs        = out_valid && out_ready;
   assign frame_end = hs && out_last;
   assign feed      = hs && (ph != PH_FCS);
   assign ins_busy  = (ph != PH_DATA);
   assign pad_on    = (ph == PH_PAD);

   fpf_crc32 #(
      .DATA_W    (DATA_W),
      .NIB_TABLE (NIB_TABLE)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_end),
      .en    (feed),
      .din   (out_data),
      .crc_q (crc_q)
   );

   fpf_len_cnt #(
      .LIMIT (PAY_MIN),
      .CW    (CW)
   ) u_len (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_end),
      .inc   (feed),
      .cnt   (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_DATA;
         nopad_q <= 1'b0;
         nocrc_q <= 1'b0;
         fidx    <= '0;
      end else if (hs) begin
         unique case (ph)
            PH_DATA: begin
               if (in_first) begin
                  nopad_q <= in_nopad;
                  nocrc_q <= in_nocrc;
               end
               fidx <= '0;
               if (in_last) begin
                  if (need_pad)      ph <= PH_PAD;
                  else if (need_fcs) ph <= PH_FCS;
               end
            end
            PH_PAD: begin
               if (cnt_plus >= PAY_MIN_V) ph <= PH_FCS;
            end
            PH_FCS: begin
               fidx <= fidx + 1'b1;
               if (fidx == 2'd3) ph <= PH_DATA;
            end
            default: ph <= PH_DATA;
         endcase
      end
   end

endmodule

// File: rtl/frame_pad_fcs_chk.sv
module frame_pad_fcs_chk #(
   parameter int DATA_W    = 8,
   parameter int MIN_FRAME = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_ready,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last,
   input logic              ins_busy,
   input logic              pad_on
);
   logic [15:0] beat_cnt;
   logic        saw_pad;
   logic        hs;

   assign hs = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_cnt <= '0;
         saw_pad  <= 1'b0;
      end else if (hs) begin
         if (out_last) begin
            beat_cnt <= '0;
            saw_pad  <= 1'b0;
         end else begin
            if (beat_cnt != 16'hFFFF) beat_cnt <= beat_cnt + 1'b1;
            if (pad_on) saw_pad <= 1'b1;
         end
      end
   end

   // R1
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_busy && in_valid) |-> (out_valid && out_data == in_data));

   // R4
   padded_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && out_last && saw_pad) |-> (beat_cnt == 16'(MIN_FRAME - 1)));

   // R8
   end_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && out_last) |=> !ins_busy);

   // R9
   no_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_busy |-> (!in_ready && out_valid));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && ins_busy) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind frame_pad_fcs frame_pad_fcs_chk #(
   .DATA_W    (DATA_W),
   .MIN_FRAME (MIN_FRAME)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last),
   .ins_busy  (ins_busy),
   .pad_on    (pad_on)
);

// File: tb/sim_frame_pad_fcs.sv
`timescale 1ns/1ps
module sim_frame_pad_fcs;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
   logic       in_nopad = 1'b0, in_nocrc = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic       out_valid, out_first, out_last;
   logic       out_ready = 1'b1;
   logic [7:0] out_data;

   int checks = 0;
   int errors = 0;
   int cyc_total = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   frame_pad_fcs u0 (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_first(in_first), .in_last(in_last),
      .in_nopad(in_nopad), .in_nocrc(in_nocrc),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_first(out_first), .out_last(out_last)
   );

   logic [7:0] in_b  [0:127];
   logic [7:0] exp_b [0:127];
   logic [7:0] got_b [0:127];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_fcs(input int n);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < n; i++) begin
         c = c ^ {24'd0, exp_b[i]};
         for (int b = 0; b < 8; b++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
      return ~c;
   endfunction

   // drives one frame, collects the output and judges it
   task automatic run_frame(input string req, input int len, input int seed,
                            input bit nopad, input bit nocrc,
                            input bit late_nopad, input bit late_nocrc,
                            input bit bp);
      int exp_n, got_n, idx, cyc, bad_pos, first_bad, last_bad, ready_bad, stall_bad;
      bit padded, fcs_on, done, stalled;
      logic [7:0] stall_val;
      logic [31:0] f;
      for (int i = 0; i < len; i++) in_b[i] = 8'((seed + i * 37) ^ (i >> 2));
      for (int i = 0; i < len; i++) exp_b[i] = in_b[i];
      exp_n  = len;
      padded = !nopad && (len < 60);
      if (padded) begin
         for (int i = len; i < 60; i++) exp_b[i] = 8'h00;
         exp_n = 60;
      end
      fcs_on = padded || !nocrc;
      if (fcs_on) begin
         f = ref_fcs(exp_n);
         for (int k = 0; k < 4; k++) exp_b[exp_n + k] = f[8*k +: 8];
         exp_n += 4;
      end
      idx = 0; got_n = 0; cyc = 0; done = 0;
      bad_pos = -1; first_bad = 0; last_bad = 0; ready_bad = 0; stall_bad = 0;
      stalled = 0; stall_val = '0;
      while (!done && cyc < 3000) begin
         @(negedge clk);
         out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
         if (idx < len) begin
            in_valid = 1'b1;
            in_data  = in_b[idx];
            in_first = (idx == 0);
            in_last  = (idx == len - 1);
            in_nopad = (idx == 0) ? nopad : late_nopad;
            in_nocrc = (idx == 0) ? nocrc : late_nocrc;
         end else begin
            in_valid = 1'b0;
            in_first = 1'b0;
            in_last  = 1'b0;
         end
         #1;
         if (stalled && out_valid && out_data !== stall_val) stall_bad++;
         stalled   = out_valid && !out_ready;
         stall_val = out_data;
         if (idx >= len && out_valid && in_ready) ready_bad++;
         if (out_valid && out_ready) begin
            if (got_n < 128) got_b[got_n] = out_data;
            if (out_first !== (got_n == 0)) first_bad++;
            if (out_last) done = 1;
            if (out_last && got_n != exp_n - 1) last_bad++;
            got_n++;
         end
         if (in_valid && in_ready) idx++;
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; out_ready = 1'b1;
      for (int i = 0; i < exp_n && i < got_n && i < 128; i++)
         if (bad_pos < 0 && got_b[i] !== exp_b[i]) bad_pos = i;
      check(done, req, "frame end seen", int'(done), 1);
      check(got_n == exp_n, req, "output length", got_n, exp_n);
      if (bad_pos >= 0)
         check(0, req, $sformatf("byte %0d", bad_pos), got_b[bad_pos], exp_b[bad_pos]);
      else
         check(1, req, "content", 0, 0);
      check(first_bad == 0, "R1", "first marker", first_bad, 0);
      check(last_bad == 0, "R8", "last marker position", last_bad, 0);
      check(ready_bad == 0, "R9", "in_ready during insertion", ready_bad, 0);
      if (bp) check(stall_bad == 0, "R10", "stalled byte held", stall_bad, 0);
   endtask

   task automatic t_reset;
      #1;
      check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
      check(in_ready == out_ready, "R11", "in_ready in payload phase", int'(in_ready), int'(out_ready));
   endtask

   task automatic t_plain;            // R1 R3
      run_frame("R3", 64, 5, 0, 0, 0, 0, 0);
      run_frame("R1", 100, 77, 0, 0, 0, 0, 0);
   endtask

   task automatic t_short_pad;        // R2 boundaries
      run_frame("R2", 10, 9, 0, 0, 0, 0, 0);
      run_frame("R2", 59, 3, 0, 0, 0, 0, 0);
      run_frame("R2", 60, 14, 0, 0, 0, 0, 0);
      run_frame("R2", 1, 200, 0, 0, 0, 0, 0);
   endtask

   task automatic t_pad_forces_fcs;   // R4
      run_frame("R4", 10, 21, 0, 1, 0, 1, 0);
   endtask

   task automatic t_no_fcs;           // R5
      run_frame("R5", 70, 33, 0, 1, 0, 1, 0);
      run_frame("R5", 60, 34, 0, 1, 0, 1, 0);
   endtask

   task automatic t_nopad;            // R6
      run_frame("R6", 12, 40, 1, 0, 1, 0, 0);
      run_frame("R6", 12, 41, 1, 1, 1, 1, 0);
   endtask

   task automatic t_late_ctrl;        // R7
      run_frame("R7", 70, 50, 0, 0, 1, 1, 0);
      run_frame("R7", 5, 51, 0, 0, 1, 1, 0);
      run_frame("R7", 8, 52, 1, 1, 0, 0, 0);
   endtask

   task automatic t_backpressure;     // R10
      run_frame("R10", 20, 60, 0, 0, 0, 0, 1);
      run_frame("R10", 70, 61, 0, 1, 0, 1, 1);
   endtask

   task automatic finish_run;
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total == 150000 && !finished) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual=%0d expected=%0d", cyc_total, 0);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain();
      t_short_pad();
      t_pad_forces_fcs();
      t_no_fcs();
      t_nopad();
      t_late_ctrl();
      t_backpressure();
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule